// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh and Power-up Sequencer

This block keeps an asynchronous DRAM alive by issuing refresh cycles in which the column strobes fall before the row strobe, so the memory uses its own internal row counter and no row address is presented. Out of reset it holds the bus, waits out the power-up pause, then runs a fixed burst of refresh cycles. Only after that burst does it raise the ready output that releases the access controller.

In normal operation an interval timer produces one refresh credit per slot of the retention period divided by the row count (15.6 µs for both the 1k and the 4k device). Credits collect in a small saturating backlog. While any credit is held and the sequencer is idle, the block raises a request toward the access controller. The controller answers with a one-cycle grant when it has parked its own access. The sequencer then owns the strobes for one full refresh cycle. All timings are parameters counted in clock cycles.

Top module: `cbr_refresh_ctrl`

## Requirements
- R1: From reset until PWR_WAIT_CYC clock cycles after reset is released, every strobe stays high (inactive), ready and request are low, and the bus-own output is high. The first column-strobe fall comes exactly PWR_WAIT_CYC cycles after reset release.
- R2: After the pause, exactly INIT_REFRESHES refresh cycles run back to back with no grant needed. Ready rises when the last one finishes and never falls until reset. The request stays low while ready is low.
- R3: In every refresh cycle, both column strobes (cas_n_o[0] and cas_n_o[1]) move together. They fall CSR_CYC cycles before the row strobe falls and rise CHR_CYC cycles after it falls, while the row strobe is still low.
- R4: The row strobe stays low for exactly RAS_CYC cycles. At least RP_CYC cycles pass from its rise to the next column-strobe fall.
- R5: The write-enable output (active low) is high in every cycle.
- R6: Once ready, a refresh credit is added every INTERVAL_CYC cycles. While the backlog is drained, consecutive request rises are exactly INTERVAL_CYC cycles apart.
- R7: A refresh starts only when the grant is sampled high while the request is high. In the next cycle the bus-own output is high and the column strobes are low. Without a grant, the strobes stay inactive and bus-own stays low.
- R8: The backlog saturates at MAX_PENDING credits. After a long stretch without grants, exactly MAX_PENDING refreshes are served before the request drops.
- R9: A timer credit that lands in the same cycle as an accepted grant is kept. The backlog then holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt_i | input | 1 | Grant from the access controller, one cycle |
| ref_req_o | output | 1 | Refresh request, high while a credit is pending and the sequencer is idle |
| mem_ready_o | output | 1 | High once the power-up burst is complete |
| bus_own_o | output | 1 | High while this block drives the DRAM strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | BYTE_LANES | Column strobes, one per byte lane, active low |
| we_n_o | output | 1 | Write enable, active low, held high |

## Verification
Two events can land in the same cycle: the interval timer adding a credit and an accepted grant taking one. The bench first lines up with the timer phase by noting the cycle in which the request rises from an empty backlog. It then places the grant exactly INTERVAL_CYC cycles later, so both events hit the same edge. The result is judged at the ports. One more refresh must be requested at once after the first one. After that refresh the request must stay low. A design that drops either the increment or the decrement breaks one of these two observations.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

    typedef enum logic [2:0] {
        PH_POWERUP,
        PH_IDLE,
        PH_CAS_LEAD,
        PH_RAS_CAS,
        PH_RAS_ONLY,
        PH_PRECHARGE
    } ref_phase_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic strobe_t phase_strobes(ref_phase_e p);
        strobe_t s;
        s = '{ras_n: 1'b1, cas_n: 1'b1};
        unique case (p)
            PH_CAS_LEAD:  s = '{ras_n: 1'b1, cas_n: 1'b0};
            PH_RAS_CAS:   s = '{ras_n: 1'b0, cas_n: 1'b0};
            PH_RAS_ONLY:  s = '{ras_n: 1'b0, cas_n: 1'b1};
            default:      s = '{ras_n: 1'b1, cas_n: 1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q == '0) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == '0);

    // R6: credits are spaced, never two in adjacent cycles
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick_o && INTERVAL_CYC > 1) |=> !tick_o);

endmodule

// File: rtl/cbr_backlog.sv
module cbr_backlog #(
    parameter int unsigned MAX_PENDING = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic take_i,
    output logic avail_o
);
    localparam int unsigned PW = $clog2(MAX_PENDING + 1);
    localparam logic [PW-1:0] FULL = PW'(MAX_PENDING);

    logic [PW-1:0] pend_q, pend_d;

    always_comb begin
        pend_d = pend_q;
        unique case ({tick_i, take_i})
            2'b10:   if (pend_q != FULL) pend_d = pend_q + 1'b1;
            2'b01:   pend_d = pend_q - 1'b1;
            default: pend_d = pend_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign avail_o = (pend_q != '0);

    // R8: backlog never exceeds its ceiling
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        pend_q <= FULL);

    // R8: a credit is only consumed when one is held
    a_r8_take_needs_credit: assert property (@(posedge clk) disable iff (rst)
        take_i |-> (pend_q != '0));

    // R9: coincident credit and take leave the backlog unchanged
    a_r9_tick_take_balance: assert property (@(posedge clk) disable iff (rst)
        (tick_i && take_i) |=> (pend_q == $past(pend_q)));

endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
    import cbr_refresh_pkg::*;
#(
    parameter int unsigned PWR_WAIT_CYC   = 20000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned CSR_CYC        = 1,
    parameter int unsigned CHR_CYC        = 1,
    parameter int unsigned RAS_CYC        = 6,
    parameter int unsigned RP_CYC         = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic own_o,
    output logic idle_o,
    output logic ready_o
);
    localparam int unsigned PH_W   = $clog2(max_of4(CSR_CYC, RAS_CYC, RP_CYC, 1) + 1);
    localparam int unsigned WAIT_W = $clog2(PWR_WAIT_CYC + 1);
    localparam int unsigned INIT_W = $clog2(INIT_REFRESHES + 1);
    localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_REFRESHES - 1);

    function automatic logic [PH_W-1:0] phase_load(ref_phase_e p);
        int unsigned n;
        unique case (p)
            PH_CAS_LEAD:  n = CSR_CYC;
            PH_RAS_CAS:   n = CHR_CYC;
            PH_RAS_ONLY:  n = RAS_CYC - CHR_CYC;
            PH_PRECHARGE: n = RP_CYC;
            default:      n = 1;
        endcase
        return PH_W'(n - 1);
    endfunction

    ref_phase_e        phase_q, phase_d;
    logic [PH_W-1:0]   ph_cnt_q, ph_cnt_d;
    logic [WAIT_W-1:0] wait_q;
    logic [INIT_W-1:0] init_q;
    logic              ready_q;
    logic              ph_done, cycle_end, last_init;
    strobe_t           strobe_q, strobe_d;

    assign ph_done   = (ph_cnt_q == '0);
    assign cycle_end = (phase_q == PH_PRECHARGE) && ph_done;
    assign last_init = (init_q == INIT_LAST);

    always_comb begin
        phase_d  = phase_q;
        ph_cnt_d = (ph_cnt_q != '0) ? ph_cnt_q - 1'b1 : '0;
        unique case (phase_q)
            PH_POWERUP:   if (wait_q == '0) phase_d = PH_CAS_LEAD;
            PH_IDLE:      if (start_i)      phase_d = PH_CAS_LEAD;
            PH_CAS_LEAD:  if (ph_done)      phase_d = PH_RAS_CAS;
            PH_RAS_CAS:   if (ph_done)      phase_d = PH_RAS_ONLY;
            PH_RAS_ONLY:  if (ph_done)      phase_d = PH_PRECHARGE;
            PH_PRECHARGE: if (ph_done)
                              phase_d = (!ready_q && !last_init) ? PH_CAS_LEAD : PH_IDLE;
            default:      phase_d = PH_IDLE;
        endcase
        if (phase_d != phase_q) ph_cnt_d = phase_load(phase_d);
        strobe_d = phase_strobes(phase_d);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_POWERUP;
            ph_cnt_q <= '0;
            wait_q   <= WAIT_W'(PWR_WAIT_CYC - 1);
            init_q   <= '0;
            ready_q  <= 1'b0;
            strobe_q <= '{ras_n: 1'b1, cas_n: 1'b1};
        end else begin
            phase_q  <= phase_d;
            ph_cnt_q <= ph_cnt_d;
            strobe_q <= strobe_d;
            if (phase_q == PH_POWERUP && wait_q != '0) wait_q <= wait_q - 1'b1;
            if (cycle_end && !ready_q) begin
                if (last_init) ready_q <= 1'b1;
                else           init_q  <= init_q + 1'b1;
            end
        end
    end

    assign ras_n_o = strobe_q.ras_n;
    assign cas_n_o = strobe_q.cas_n;
    assign own_o   = (phase_q != PH_IDLE);
    assign idle_o  = (phase_q == PH_IDLE);
    assign ready_o = ready_q;

    // Row-strobe low-run counter used by the width check below
    logic [PH_W-1:0] ras_run_q;
    always_ff @(posedge clk) begin
        if (rst || ras_n_o) ras_run_q <= '0;
        else                ras_run_q <= ras_run_q + 1'b1;
    end

    // R1: both strobes inactive during the power-up pause
    a_r1_quiet_powerup: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_POWERUP) |-> (ras_n_o && cas_n_o));

    // R2: ready is sticky
    a_r2_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> ready_o);

    // R3: column strobe already low in the cycle before the row strobe falls
    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> $past(!cas_n_o));

    // R3: column strobe releases while the row strobe is still low
    a_r3_cas_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n_o) |-> !ras_n_o);

    // R4: row-strobe pulse width
    a_r4_ras_width: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n_o) |-> (ras_run_q == PH_W'(RAS_CYC)));

endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl #(
    parameter int unsigned PWR_WAIT_CYC   = 20000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned INTERVAL_CYC   = 1560,
    parameter int unsigned MAX_PENDING    = 8,
    parameter int unsigned CSR_CYC        = 1,
    parameter int unsigned CHR_CYC        = 1,
    parameter int unsigned RAS_CYC        = 6,
    parameter int unsigned RP_CYC         = 5,
    parameter int unsigned BYTE_LANES     = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ref_gnt_i,
    output logic                  ref_req_o,
    output logic                  mem_ready_o,
    output logic                  bus_own_o,
    output logic                  ras_n_o,
    output logic [BYTE_LANES-1:0] cas_n_o,
    output logic                  we_n_o
);
    logic tick, credit, take, idle, cas_n, ready;

    assign ref_req_o   = credit && idle && ready;
    assign take        = ref_req_o && ref_gnt_i;
    assign mem_ready_o = ready;
    assign we_n_o      = 1'b1;

    cbr_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ready),
        .tick_o (tick)
    );

    cbr_backlog #(.MAX_PENDING(MAX_PENDING)) u_backlog (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .take_i  (take),
        .avail_o (credit)
    );

    cbr_strobe_seq #(
        .PWR_WAIT_CYC   (PWR_WAIT_CYC),
        .INIT_REFRESHES (INIT_REFRESHES),
        .CSR_CYC        (CSR_CYC),
        .CHR_CYC        (CHR_CYC),
        .RAS_CYC        (RAS_CYC),
        .RP_CYC         (RP_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (take),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n),
        .own_o   (bus_own_o),
        .idle_o  (idle),
        .ready_o (ready)
    );

    for (genvar g = 0; g < BYTE_LANES; g++) begin : g_lane
        assign cas_n_o[g] = cas_n;
    end

    // R2: no request before the power-up burst completes
    a_r2_no_req_before_ready: assert property (@(posedge clk) disable iff (rst)
        !mem_ready_o |-> !ref_req_o);

    // R7: request and bus ownership are exclusive
    a_r7_req_not_busy: assert property (@(posedge clk) disable iff (rst)
        ref_req_o |-> !bus_own_o);

    // R7: in normal mode a column-strobe fall follows an accepted grant
    a_r7_grant_starts: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_own_o) == 1'b0 && mem_ready_o && $past(mem_ready_o) &&
         $rose(bus_own_o)) |-> $past(ref_gnt_i && ref_req_o));

endmodule

// File: tb/cbr_refresh_ctrl_bench.sv
module cbr_refresh_ctrl_bench;
    localparam int PWR   = 50;
    localparam int INIT  = 8;
    localparam int IVL   = 60;
    localparam int MAXP  = 3;
    localparam int CSR   = 1;
    localparam int CHR   = 1;
    localparam int RASW  = 6;
    localparam int RP    = 5;
    localparam int LANES = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic req, ready, own, ras_n, we_n;
    logic [LANES-1:0] cas_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cbr_refresh_ctrl #(
        .PWR_WAIT_CYC(PWR), .INIT_REFRESHES(INIT), .INTERVAL_CYC(IVL),
        .MAX_PENDING(MAXP), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASW),
        .RP_CYC(RP), .BYTE_LANES(LANES)
    ) u_cbr_refresh_ctrl (
        .clk(clk), .rst(rst), .ref_gnt_i(gnt), .ref_req_o(req),
        .mem_ready_o(ready), .bus_own_o(own), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .we_n_o(we_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Port monitor for strobe timing
    int  ras_falls = 0;
    int  first_cas = -1;
    int  cas_fall_c = 0, ras_fall_c = 0, ras_rise_c = 0;
    bit  seen_rise = 1'b0, req_early = 1'b0, own_seen = 1'b0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            chk(we_n == 1'b1, "R5 write enable high", int'(we_n), 1);
            chk(cas_n[0] == cas_n[1], "R3 lanes move together", int'(cas_n[1]), int'(cas_n[0]));
            if (prev_cas && !cas_n[0]) begin
                if (first_cas < 0) first_cas = cyc;
                cas_fall_c = cyc;
                if (seen_rise)
                    chk(cyc - ras_rise_c >= RP, "R4 precharge before cas fall", cyc - ras_rise_c, RP);
            end
            if (prev_ras && !ras_n) begin
                ras_falls++;
                chk(cyc - cas_fall_c == CSR, "R3 cas lead", cyc - cas_fall_c, CSR);
                ras_fall_c = cyc;
            end
            if (!prev_cas && cas_n[0])
                chk(cyc - ras_fall_c == CHR && !ras_n, "R3 cas hold", cyc - ras_fall_c, CHR);
            if (!prev_ras && ras_n) begin
                chk(cyc - ras_fall_c == RASW, "R4 ras width", cyc - ras_fall_c, RASW);
                ras_rise_c = cyc;
                seen_rise = 1'b1;
            end
            if (!ready && req) req_early = 1'b1;
            if (own) own_seen = 1'b1;
            prev_ras = ras_n;
            prev_cas = cas_n[0];
        end
    end

    task automatic serve(input int max_n, output int n);
        int idle;
        n = 0;
        idle = 0;
        while (idle < 16 && n < max_n) begin
            @(negedge clk);
            if (req) begin
                gnt = 1'b1;
                @(negedge clk);
                gnt = 1'b0;
                n++;
                idle = 0;
                chk(own && cas_n == '0, "R7 strobes after grant", int'(own), 1);
            end else begin
                idle++;
            end
        end
    endtask

    task automatic wait_req(output int at);
        at = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (req) begin
                at = cyc;
                break;
            end
        end
    endtask

    int rel_c;

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(!ready && ras_n && cas_n == '1 && !req && own, "R1 reset state",
            {ready, ras_n, req, own}, 4'b0101);
        rst = 1'b0;
        rel_c = cyc;
    endtask

    task automatic t_powerup();
        for (int i = 0; i < PWR - 2; i++) begin
            @(negedge clk);
            if (i == PWR - 3)
                chk(ras_n && cas_n == '1 && own && !ready, "R1 quiet pause",
                    int'(ras_n), 1);
        end
        for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
        chk(first_cas - rel_c == PWR, "R1 first cas fall", first_cas - rel_c, PWR);
        chk(ready == 1'b1, "R2 ready raised", int'(ready), 1);
        chk(ras_falls == INIT, "R2 init burst count", ras_falls, INIT);
        chk(!req_early, "R2 no request before ready", int'(req_early), 0);
        repeat (3) @(negedge clk);
        chk(!own && ready, "R2 idle after burst", int'(own), 0);
    endtask

    task automatic t_interval();
        int n, a, b;
        serve(MAXP + 2, n);
        wait_req(a);
        serve(1, n);
        wait_req(b);
        chk(b - a == IVL, "R6 credit spacing", b - a, IVL);
        serve(1, n);
    endtask

    task automatic t_saturate();
        int n, a, f0;
        bit own_any;
        serve(MAXP + 2, n);
        wait_req(a);
        f0 = ras_falls;
        own_any = 1'b0;
        for (int i = 0; i < 4 * IVL; i++) begin
            @(negedge clk);
            if (own) own_any = 1'b1;
        end
        chk(ras_falls == f0 && !own_any, "R7 idle without grant", ras_falls - f0, 0);
        serve(MAXP + 3, n);
        chk(n == MAXP, "R8 saturated backlog served", n, MAXP);
    endtask

    task automatic t_coincide();
        int n, a;
        serve(MAXP + 2, n);
        wait_req(a);
        repeat (IVL - 1) @(negedge clk);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        chk(own, "R9 grant on credit edge accepted", int'(own), 1);
        serve(1, n);
        chk(n == 1, "R9 credit kept after coincidence", n, 1);
        serve(1, n);
        chk(n == 0, "R9 no extra credit after coincidence", n, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_interval();
        t_saturate();
        t_coincide();
        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

endmodule